// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a small stored-program processor built around one 16-bit accumulator. Instructions and data share a single memory of 4096 16-bit words. Each instruction word holds a 4-bit operation code in bits [15:12] and a 12-bit operand address S in bits [11:0]. The core has a program counter, an accumulator, an instruction register and an ALU. A hardwired state machine drives them, and two steering multiplexers sit in the datapath. The address multiplexer picks either the program counter or the operand field. The ALU's first input picks either the accumulator or the program counter.

The memory port has a request strobe, a read-not-write select, an address, and separate read-data and write-data buses. A read is answered one cycle after its request. The controller therefore spends a wait cycle after every read.

The controller has five states:
- FETCH issues a read at PC and goes to LATCH.
- LATCH captures the instruction word and increments PC through the ALU, then goes to EXEC.
- EXEC acts on the operation code. Load, add and subtract issue an operand read and go to OPERAND. A store writes the accumulator and returns to FETCH. Jumps and unused codes return to FETCH. Stop goes to HALT.
- OPERAND combines the returned word into the accumulator and goes to FETCH.
- HALT is absorbing until reset.

Top module: `acc_core`

## Requirements
- R1: A synchronous reset clears PC and the accumulator to zero and enters FETCH. While reset is held, and in the first cycle after it, the core requests a read (`mem_rnw`=1) at address 0 and `halted` is low.
- R2: Instructions are fetched from consecutive addresses starting at PC. Each memory read is followed by one cycle with no request. For the sequence load 0x080, unused code, store 0x090, stop placed at 0..3, the request addresses are 0, 0x080, 1, 2, 0x090, 3 in that order.
- R3: Opcode 0000 loads the accumulator with mem[S].
- R4: Opcode 0001 issues one write cycle (`mem_rnw`=0) at S carrying the accumulator. `mem_wdata` is zero whenever no write is in progress.
- R5: Opcode 0010 sets the accumulator to its value plus mem[S], modulo 2^16.
- R6: Opcode 0011 sets the accumulator to its value minus mem[S], modulo 2^16.
- R7: Opcode 0100 sets PC to S, so the word after the jump is skipped.
- R8: Opcode 0101 sets PC to S when the accumulator's bit 15 is 0. Otherwise it continues at the next word.
- R9: Opcode 0110 sets PC to S when the accumulator is nonzero. Otherwise it continues at the next word.
- R10: Opcode 0111 raises `halted`, which stays high until reset. While `halted` is high, `mem_req` stays low.
- R11: Opcodes 1000 through 1111 change neither the accumulator nor memory, and execution continues at the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| mem_req | output | 1 | Memory access strobe |
| mem_rnw | output | 1 | 1 = read, 0 = write |
| mem_addr | output | 12 | Word address of the access |
| mem_wdata | output | 16 | Accumulator value during a store, zero otherwise |
| halted | output | 1 | High after a stop instruction until reset |

## Verification
The bound checker watches the memory handshake on every cycle:
- a read is always followed by an idle cycle;
- a write is always followed by a fetch;
- write data stays at zero outside stores;
- the halt flag is sticky and keeps the bus quiet;
- the core restarts at address 0 after reset.

The arithmetic results, the taken and not-taken decisions of both conditional jumps, and the harmlessness of the unused opcodes can only be seen through the bench's programs. The bench sweeps pairs of corner-case operands and signed boundary values through them and compares the memory contents left behind.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int unsigned OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD  = 4'b0000,
        OP_STORE = 4'b0001,
        OP_ADD   = 4'b0010,
        OP_SUB   = 4'b0011,
        OP_JUMP  = 4'b0100,
        OP_JPOS  = 4'b0101,
        OP_JNZ   = 4'b0110,
        OP_STOP  = 4'b0111
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_LATCH,
        ST_EXEC,
        ST_OPERAND,
        ST_HALT
    } state_e;

    typedef enum logic [1:0] {
        ALU_PASS_B,
        ALU_ADD,
        ALU_SUB,
        ALU_INC
    } alu_op_e;

    typedef struct packed {
        logic    pc_we;
        logic    pc_from_ir;
        logic    acc_we;
        logic    ir_we;
        logic    addr_from_ir;
        logic    a_from_pc;
        alu_op_e alu_op;
        logic    mem_req;
        logic    mem_rnw;
        logic    acc_drive;
        logic    halted;
    } ctrl_t;

endpackage

// File: rtl/acc_core_alu.sv
module acc_core_alu
    import acc_core_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (op)
            ALU_PASS_B: y = b;
            ALU_ADD:    y = a + b;
            ALU_SUB:    y = a - b;
            ALU_INC:    y = a + W'(1);
            default:    y = b;
        endcase
    end

endmodule

// File: rtl/acc_core_ctrl.sv
module acc_core_ctrl
    import acc_core_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic             acc_neg,
    input  logic             acc_zero,
    output ctrl_t            ctl
);

    state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: state_d = ST_LATCH;
            ST_LATCH: state_d = ST_EXEC;
            ST_EXEC: begin
                case (opcode)
                    OP_LOAD, OP_ADD, OP_SUB: state_d = ST_OPERAND;
                    OP_STOP:                 state_d = ST_HALT;
                    default:                 state_d = ST_FETCH;
                endcase
            end
            ST_OPERAND: state_d = ST_FETCH;
            ST_HALT:    state_d = ST_HALT;
            default:    state_d = ST_FETCH;
        endcase
    end

    // outputs
    always_comb begin
        ctl = '0;
        ctl.mem_rnw = 1'b1;
        ctl.alu_op  = ALU_PASS_B;
        unique case (state_q)
            ST_FETCH: begin
                ctl.mem_req = 1'b1;
            end
            ST_LATCH: begin
                ctl.ir_we     = 1'b1;
                ctl.pc_we     = 1'b1;
                ctl.a_from_pc = 1'b1;
                ctl.alu_op    = ALU_INC;
            end
            ST_EXEC: begin
                case (opcode)
                    OP_LOAD, OP_ADD, OP_SUB: begin
                        ctl.mem_req      = 1'b1;
                        ctl.addr_from_ir = 1'b1;
                    end
                    OP_STORE: begin
                        ctl.mem_req      = 1'b1;
                        ctl.mem_rnw      = 1'b0;
                        ctl.addr_from_ir = 1'b1;
                        ctl.acc_drive    = 1'b1;
                    end
                    OP_JUMP: begin
                        ctl.pc_we      = 1'b1;
                        ctl.pc_from_ir = 1'b1;
                    end
                    OP_JPOS: begin
                        ctl.pc_we      = ~acc_neg;
                        ctl.pc_from_ir = 1'b1;
                    end
                    OP_JNZ: begin
                        ctl.pc_we      = ~acc_zero;
                        ctl.pc_from_ir = 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_OPERAND: begin
                ctl.acc_we = 1'b1;
                case (opcode)
                    OP_ADD:  ctl.alu_op = ALU_ADD;
                    OP_SUB:  ctl.alu_op = ALU_SUB;
                    default: ctl.alu_op = ALU_PASS_B;
                endcase
            end
            ST_HALT: begin
                ctl.halted = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W+OPC_W-1:0] mem_rdata,
    output logic                    mem_req,
    output logic                    mem_rnw,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [ADDR_W+OPC_W-1:0] mem_wdata,
    output logic                    halted
);

    localparam int unsigned DATA_W = ADDR_W + OPC_W;

    ctrl_t             ctl;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] alu_a;
    logic [DATA_W-1:0] alu_y;
    logic [ADDR_W-1:0] ir_field;

    assign ir_field = ir_q[ADDR_W-1:0];

    acc_core_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .opcode   (ir_q[DATA_W-1:ADDR_W]),
        .acc_neg  (acc_q[DATA_W-1]),
        .acc_zero (acc_q == '0),
        .ctl      (ctl)
    );

    // ALU operand A: accumulator or zero-extended program counter
    assign alu_a = ctl.a_from_pc ? {{OPC_W{1'b0}}, pc_q} : acc_q;

    acc_core_alu #(.W(DATA_W)) u_alu (
        .a  (alu_a),
        .b  (mem_rdata),
        .op (ctl.alu_op),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            acc_q <= '0;
            ir_q  <= '0;
        end else begin
            if (ctl.ir_we)  ir_q  <= mem_rdata;
            if (ctl.acc_we) acc_q <= alu_y;
            if (ctl.pc_we)  pc_q  <= ctl.pc_from_ir ? ir_field : alu_y[ADDR_W-1:0];
        end
    end

    assign mem_req   = ctl.mem_req;
    assign mem_rnw   = ctl.mem_rnw;
    assign mem_addr  = ctl.addr_from_ir ? ir_field : pc_q;
    assign mem_wdata = ctl.acc_drive ? acc_q : '0;
    assign halted    = ctl.halted;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_rnw,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              halted
);

    a_r1_restart_at_zero: assert property (@(posedge clk)
        rst |=> (mem_req && mem_rnw && mem_addr == '0 && !halted));

    a_r2_read_wait: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_rnw) |=> !mem_req);

    a_r2_write_then_fetch: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rnw) |=> (mem_req && mem_rnw));

    a_r4_wdata_quiet: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && !mem_rnw) |-> (mem_wdata == '0));

    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    a_r10_halt_no_req: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_req);

endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W), .DATA_W(ADDR_W + acc_core_pkg::OPC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_rnw   (mem_rnw),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .halted    (halted)
);

// File: tb/acc_core_tb_top.sv
module acc_core_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_rdata;
    logic        mem_req;
    logic        mem_rnw;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        halted;

    logic [15:0] mem [256];
    logic [11:0] log_a [8];
    int          log_n;
    int          vectors = 0;
    int          miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_core dut_i (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_rnw   (mem_rnw),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .halted    (halted)
    );

    // memory model: read data one cycle after request
    always @(posedge clk) begin
        if (mem_req && mem_rnw) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_req && !mem_rnw) mem[mem_addr[7:0]] <= mem_wdata;
        if (rst) log_n <= 0;
        else if (mem_req && log_n < 8) begin
            log_a[log_n] <= mem_addr;
            log_n <= log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] s);
        return {op, s};
    endfunction

    function automatic logic [15:0] val(input int k);
        case (k)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h7FFF;
            3: return 16'h8000;
            4: return 16'hFFFF;
            5: return 16'h1234;
            6: return 16'h00FF;
            default: return 16'hFF00;
        endcase
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    task automatic run_prog(input bit check_reset);
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (check_reset)
            chk(mem_req && mem_rnw && mem_addr == 12'h000 && !halted,
                "R1 reset fetch at 0", {4'h0, mem_addr}, 16'h0000);
        rst = 1'b0;
        for (int c = 0; c < 3000 && !halted; c++) @(negedge clk);
        chk(halted, "R10 halted after stop", {15'h0, halted}, 16'h0001);
        begin
            bit quiet = 1'b1;
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                if (mem_req || !halted) quiet = 1'b0;
            end
            chk(quiet, "R10 halt sticky and bus idle", {15'h0, quiet}, 16'h0001);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        miscompares++;
        vectors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        bit first = 1'b1;
        // arithmetic sweep: R3 R4 R5 R6
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [15:0] a, b;
                a = val(i);
                b = val(j);
                clear_mem();
                mem[0] = ins(4'h0, 12'h080);
                mem[1] = ins(4'h1, 12'h092);
                mem[2] = ins(4'h2, 12'h081);
                mem[3] = ins(4'h1, 12'h090);
                mem[4] = ins(4'h0, 12'h080);
                mem[5] = ins(4'h3, 12'h081);
                mem[6] = ins(4'h1, 12'h091);
                mem[7] = ins(4'h7, 12'h000);
                mem[8'h80] = a;
                mem[8'h81] = b;
                run_prog(first);
                first = 1'b0;
                chk(mem[8'h92] == a, "R3 load then R4 store", mem[8'h92], a);
                chk(mem[8'h90] == 16'(a + b), "R5 add", mem[8'h90], 16'(a + b));
                chk(mem[8'h91] == 16'(a - b), "R6 sub", mem[8'h91], 16'(a - b));
            end
        end
        // conditional and unconditional jumps: R7 R8 R9
        for (int i = 0; i < 8; i++) begin
            logic [15:0] v, e8, e9;
            v = val(i);
            e8 = v[15] ? 16'hAAAA : 16'h5555;
            e9 = (v != 0) ? 16'h5555 : 16'hAAAA;
            clear_mem();
            mem[0]  = ins(4'h0, 12'h080);
            mem[1]  = ins(4'h5, 12'h004);
            mem[2]  = ins(4'h0, 12'h083);
            mem[3]  = ins(4'h4, 12'h005);
            mem[4]  = ins(4'h0, 12'h084);
            mem[5]  = ins(4'h1, 12'h090);
            mem[6]  = ins(4'h0, 12'h080);
            mem[7]  = ins(4'h6, 12'h00A);
            mem[8]  = ins(4'h0, 12'h083);
            mem[9]  = ins(4'h4, 12'h00B);
            mem[10] = ins(4'h0, 12'h084);
            mem[11] = ins(4'h1, 12'h091);
            mem[12] = ins(4'h4, 12'h00E);
            mem[13] = ins(4'h1, 12'h093);
            mem[14] = ins(4'h7, 12'h000);
            mem[8'h80] = v;
            mem[8'h83] = 16'hAAAA;
            mem[8'h84] = 16'h5555;
            mem[8'h93] = 16'hDEAD;
            run_prog(1'b0);
            chk(mem[8'h90] == e8, "R8 jump if non-negative", mem[8'h90], e8);
            chk(mem[8'h91] == e9, "R9 jump if nonzero", mem[8'h91], e9);
            chk(mem[8'h93] == 16'hDEAD, "R7 jump skips next word", mem[8'h93], 16'hDEAD);
        end
        // unused opcodes: R11, plus request order R2
        for (int op = 8; op < 16; op++) begin
            clear_mem();
            mem[0] = ins(4'h0, 12'h080);
            mem[1] = ins(4'(op), 12'h081);
            mem[2] = ins(4'h1, 12'h090);
            mem[3] = ins(4'h7, 12'h000);
            mem[8'h80] = 16'h1111;
            mem[8'h81] = 16'h2222;
            run_prog(1'b0);
            chk(mem[8'h90] == 16'h1111, "R11 acc untouched by unused code", mem[8'h90], 16'h1111);
            chk(mem[8'h81] == 16'h2222, "R11 memory untouched by unused code", mem[8'h81], 16'h2222);
            if (op == 8) begin
                logic [11:0] exp_a [6];
                exp_a = '{12'h000, 12'h080, 12'h001, 12'h002, 12'h090, 12'h003};
                chk(log_n == 6, "R2 request count", 16'(log_n), 16'd6);
                for (int k = 0; k < 6; k++)
                    chk(log_a[k] == exp_a[k], "R2 request address order",
                        {4'h0, log_a[k]}, {4'h0, exp_a[k]});
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule